// File: doc/BRIEF.md
# Hot-Plug Interrupt Locator Aggregator

This block sits beside the slot registers of a hot-plug controller and folds their pending state into a single interrupt summary. Each slot contributes one byte of latched events and one byte of per-event masks; a slot is flagged when at least one latched event is not masked. A command-completion event, taken from a global control word, is flagged alongside the slots. The result is a 32-bit locator word that software reads to find which sources want service. Bit 0 of the word belongs to command completion, and a slot with index `s` appears at bit `s+1`.

From the locator word and a global interrupt-disable bit the block derives one interrupt level. That level is delivered in one of two ways. With message signalling off, it drives a wired level line. With message signalling on, the wired line stays low and a single-cycle pulse marks every cycle in which the level differs from the level remembered from the previous clock. The remembered level is cleared by reset, so a condition that is still pending when reset ends produces a fresh pulse. The slot count is a parameter from 1 to 31. Event generation, register decode and bus transport are handled elsewhere.

Top module: `hpl_locator_agg`

## Requirements
- R1: For every slot index `s` below NSLOTS, locator bit `s+1` is 1 exactly when the bitwise AND of that slot's event byte (`slot_event_i[8*s+7:8*s]`) with the inverse of its mask byte (`slot_mask_i[8*s+7:8*s]`) is nonzero, combinationally in the same cycle.
- R2: Locator bit 0 is 1 exactly when control bit 16 (command detected) is 1 and control bit 2 (command interrupt disable) is 0, outside reset.
- R3: Locator bits NSLOTS+1 through 31 are always 0.
- R4: The interrupt level is 1 exactly when control bit 0 (global interrupt disable) is 0 and the locator word is nonzero; with `msg_en_i` low, `irq_o` equals this level and `msg_pulse_o` is 0.
- R5: With `msg_en_i` high, `irq_o` is 0 and `msg_pulse_o` is 1 exactly in the cycles where the current level differs from the level registered at the previous clock edge (rising and falling changes both pulse).
- R6: Reset clears the remembered level; a level of 1 present in the first cycle after reset is released gives a pulse in that cycle when `msg_en_i` is high.
- R7: While `rst_n` is low, control bits 0 to 3 are treated as set: `irq_o`, `msg_pulse_o` and locator bit 0 are 0, while the slot bits still follow R1.
- R8: `irq_o` and `msg_pulse_o` are never 1 in the same cycle.
- R9: Control bits 1 and 3 and every control bit other than 0, 2 and 16 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_event_i | input | NSLOTS*8 | Latched event byte per slot, slot `s` at bits `8*s+7:8*s` |
| slot_mask_i | input | NSLOTS*8 | Mask byte per slot, same layout; a 1 masks the event bit |
| ctrl_i | input | 32 | Global control word: bit 0 global disable, bit 2 command disable, bit 16 command detected |
| msg_en_i | input | 1 | Selects message-signalled delivery |
| locator_o | output | 32 | Interrupt locator word |
| irq_o | output | 1 | Wired interrupt level |
| msg_pulse_o | output | 1 | Single-cycle message notification |

## Verification
On every cycle the assertions hold the two delivery paths apart, keep the wired line low under global disable or an empty locator, tie locator bit 0 to the command-detected flag, and forbid a message pulse when the level has not changed or message signalling is off. The exact mapping from event and mask bytes to locator bits, the silence of the upper bits, the effect of reset on the control bits and the fresh pulse right after reset release are only shown by the bench's scenarios, which sweep event and mask bytes on every slot of a four-slot build and compare against values computed from the requirements.

// File: rtl/hpl_pkg.sv
package hpl_pkg;

    localparam int LOC_W       = 32;
    localparam int EV_W        = 8;
    localparam int MAX_SLOTS   = 31;

    localparam int CTL_GDIS    = 0;
    localparam int CTL_ERRDIS  = 1;
    localparam int CTL_CMDDIS  = 2;
    localparam int CTL_ARBDIS  = 3;
    localparam int CTL_CMDDET  = 16;

    localparam logic [LOC_W-1:0] CTL_RST_DIS = 32'h0000_000F;

    typedef struct packed {
        logic level;
    } notify_state_t;

endpackage

// File: rtl/hpl_slot_bank.sv
module hpl_slot_bank
    import hpl_pkg::*;
#(
    parameter int NSLOTS = 31
) (
    input  logic [NSLOTS*EV_W-1:0] event_i,
    input  logic [NSLOTS*EV_W-1:0] mask_i,
    output logic [NSLOTS-1:0]      hit_o
);

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        logic [EV_W-1:0] open_ev;
        always_comb begin
            open_ev  = event_i[s*EV_W +: EV_W] & ~mask_i[s*EV_W +: EV_W];
            hit_o[s] = |open_ev;
        end
    end

endmodule

// File: rtl/hpl_cmd_event.sv
module hpl_cmd_event
    import hpl_pkg::*;
(
    input  logic [LOC_W-1:0] ctrl_eff_i,
    output logic             cmd_hit_o
);

    always_comb begin
        cmd_hit_o = ctrl_eff_i[CTL_CMDDET] & ~ctrl_eff_i[CTL_CMDDIS];
    end

endmodule

// File: rtl/hpl_irq_notify.sv
module hpl_irq_notify
    import hpl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOC_W-1:0] locator_i,
    input  logic             gdis_i,
    input  logic             msg_en_i,
    output logic             level_o,
    output logic             irq_o,
    output logic             msg_pulse_o
);

    notify_state_t st_d, st_q;
    logic          level;

    always_comb begin
        level       = ~gdis_i & (|locator_i);
        st_d        = st_q;
        st_d.level  = level;
        msg_pulse_o = msg_en_i & (level != st_q.level);
        irq_o       = ~msg_en_i & level;
        level_o     = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a pulse only ever appears in message mode
    assert_pulse_needs_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse_o |-> msg_en_i);

endmodule

// File: rtl/hpl_locator_agg.sv
module hpl_locator_agg
    import hpl_pkg::*;
#(
    parameter int NSLOTS = 31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOTS*EV_W-1:0] slot_event_i,
    input  logic [NSLOTS*EV_W-1:0] slot_mask_i,
    input  logic [LOC_W-1:0]       ctrl_i,
    input  logic                   msg_en_i,
    output logic [LOC_W-1:0]       locator_o,
    output logic                   irq_o,
    output logic                   msg_pulse_o
);

    logic [NSLOTS-1:0] slot_hit;
    logic              cmd_hit;
    logic [LOC_W-1:0]  ctrl_eff;
    logic              level;

    always_comb begin
        ctrl_eff = rst_n ? ctrl_i : (ctrl_i | CTL_RST_DIS);
    end

    hpl_slot_bank #(.NSLOTS(NSLOTS)) u_bank (
        .event_i (slot_event_i),
        .mask_i  (slot_mask_i),
        .hit_o   (slot_hit)
    );

    hpl_cmd_event u_cmd (
        .ctrl_eff_i (ctrl_eff),
        .cmd_hit_o  (cmd_hit)
    );

    assign locator_o[0] = cmd_hit;
    for (genvar b = 1; b < LOC_W; b++) begin : g_loc
        if (b <= NSLOTS) begin : g_used
            assign locator_o[b] = slot_hit[b-1];
        end else begin : g_spare
            assign locator_o[b] = 1'b0;
        end
    end

    hpl_irq_notify u_notify (
        .clk         (clk),
        .rst_n       (rst_n),
        .locator_i   (locator_o),
        .gdis_i      (ctrl_eff[CTL_GDIS]),
        .msg_en_i    (msg_en_i),
        .level_o     (level),
        .irq_o       (irq_o),
        .msg_pulse_o (msg_pulse_o)
    );

    // R8: the two delivery paths never fire together
    assert_one_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && msg_pulse_o));

    // R4: global disable silences the wired line
    assert_gdis_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i[CTL_GDIS] |-> !irq_o);

    // R4: the wired line needs a pending source
    assert_irq_has_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (locator_o != '0));

    // R2: command bit only with the detected flag
    assert_cmd_bit_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locator_o[0] |-> ctrl_i[CTL_CMDDET]);

    // R5: an unchanged level gives no pulse
    assert_no_pulse_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) |-> !msg_pulse_o);

endmodule

// File: tb/hpl_locator_agg_tb.sv
module hpl_locator_agg_tb;

    localparam int NS = 4;
    localparam int EW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS*EW-1:0] ev = '0;
    logic [NS*EW-1:0] mk = '0;
    logic [31:0]     ctrl = 32'h0;
    logic            msg_en = 1'b0;
    logic [31:0]     loc;
    logic            irq;
    logic            pulse;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    hpl_locator_agg #(.NSLOTS(NS)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_event_i (ev),
        .slot_mask_i  (mk),
        .ctrl_i       (ctrl),
        .msg_en_i     (msg_en),
        .locator_o    (loc),
        .irq_o        (irq),
        .msg_pulse_o  (pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_bits(input logic [NS*EW-1:0] e, input logic [NS*EW-1:0] m);
        logic [31:0] w = '0;
        for (int s = 0; s < NS; s++) begin
            if ((e[s*EW +: EW] & ~m[s*EW +: EW]) != 8'h00) w[s+1] = 1'b1;
        end
        return w;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] expw;
        // R7: reset with everything pending
        ev = '1; mk = '0; ctrl = 32'h0001_0000; msg_en = 1'b1;
        step();
        chk("R7 loc during reset", loc, slot_bits(ev, mk));
        chk("R7 pulse during reset", {31'b0, pulse}, 32'h0);
        chk("R7 irq during reset", {31'b0, irq}, 32'h0);
        msg_en = 1'b0;
        #1;
        chk("R7 wired irq during reset", {31'b0, irq}, 32'h0);
        msg_en = 1'b1;
        step();
        // R6: release reset with level pending
        rst_n = 1'b1;
        #1;
        chk("R6 pulse after release", {31'b0, pulse}, 32'h1);
        chk("R5 irq low in msg mode", {31'b0, irq}, 32'h0);
        chk("R2 cmd bit after release", {31'b0, loc[0]}, 32'h1);
        step();
        chk("R5 pulse ends", {31'b0, pulse}, 32'h0);
        // R5: falling level pulses too
        ev = '0; ctrl = 32'h0;
        #1;
        chk("R5 pulse on fall", {31'b0, pulse}, 32'h1);
        step();
        chk("R5 no pulse while low", {31'b0, pulse}, 32'h0);
        // R4: wired mode
        msg_en = 1'b0;
        ev = '0; ev[2*EW+3] = 1'b1;
        step();
        chk("R4 irq level", {31'b0, irq}, 32'h1);
        chk("R8 no pulse in wired", {31'b0, pulse}, 32'h0);
        chk("R1 slot2 bit", loc, 32'h0000_0008);
        ctrl = 32'h1;
        step();
        chk("R4 gdis clears irq", {31'b0, irq}, 32'h0);
        chk("R4 locator kept", loc, 32'h0000_0008);
        // R9: other control bits
        ctrl = 32'hFFFE_FFFA;
        step();
        chk("R9 loc unaffected", loc, 32'h0000_0008);
        chk("R9 irq unaffected", {31'b0, irq}, 32'h1);
        // R2: command bit combos
        ev = '0;
        for (int c = 0; c < 4; c++) begin
            ctrl = 32'h0;
            ctrl[16] = c[0];
            ctrl[2]  = c[1];
            step();
            expw = {31'b0, c[0] & ~c[1]};
            chk("R2 cmd bit", loc, expw);
            chk("R4 irq from cmd", {31'b0, irq}, expw);
        end
        // R1 / R3 sweep
        ctrl = 32'h1;
        for (int s = 0; s < NS; s++) begin
            for (int e = 0; e < 256; e++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int o = 0; o < NS; o++) begin
                        ev[o*EW +: EW] = 8'((o * 37 + e) ^ 8'h5A);
                        mk[o*EW +: EW] = 8'(o * 91 + m);
                    end
                    ev[s*EW +: EW] = 8'(e);
                    mk[s*EW +: EW] = 8'(m * 17);
                    #1;
                    expw = slot_bits(ev, mk);
                    chk("R1 R3 locator", loc, expw);
                    if ((e + m) % 64 == 0) chk("R8 exclusive", {31'b0, irq & pulse}, 32'h0);
                end
            end
        end
        ev = '1; mk = '0;
        #1;
        chk("R3 spare bits", loc[31:NS+1], 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule